// File: doc/BRIEF.md
# Three-Channel Interval Timer Register Front End

This block is the byte-wide host register file that sits in front of three interval-timer counters. The host reaches it through a 2-bit address. Addresses 0, 1 and 2 are the data windows of the three channels, and address 3 takes control words.

A control word either configures one channel or asks that channel to freeze its count. Configuring sets the channel's byte access scheme, its operating mode and its BCD flag. A second control form, the read-back command, can freeze the count, the status, or both, on any subset of the channels in one write.

The block itself does not count. It passes a one-cycle load strobe with a 16-bit initial value, plus the mode and BCD settings, to each channel. In return it samples each channel's live count and output level. Data reads answer in this priority order: a pending frozen status byte first, then a frozen count, then the live count. Multi-byte values are split into bytes according to the access scheme of the channel being read.

Top module: `tmr_bus_regs`

## Requirements
- R1: A write to address 3 is a control word. Bits 7:6 hold the target, where 0 to 2 name a channel and 3 selects read-back. Bits 5:4 hold the access scheme: 00 freezes the count, 01 is low byte only, 10 is high byte only, 11 is low byte then high byte. Any other scheme stores bits 3:1 to `mode_o` and bit 0 to `bcd_o`, and restarts both the read and the write byte order at the low byte. `mode_o` changes only on such a word. A control word never pulses `load_o`.
- R2: In low-only access, a data write loads {8'h00, byte}. In high-only access, it loads {byte, 8'h00}. `load_o[ch]` pulses for one cycle, in the cycle after the write, with `load_val_o` valid in that same cycle.
- R3: In low/high access, the first data write is held and causes no load. The second write loads {second, first}.
- R4: Live reads return the low byte of `cnt_i` in low-only access and the high byte in high-only access. In low/high access they alternate, low byte first.
- R5: A freeze command captures the channel count in the write cycle. Later reads return the frozen bytes in the channel's access order, whatever `cnt_i` does in the meantime.
- R6: A freeze request is ignored while a frozen count has not been fully read.
- R7: Once a frozen count has been fully read, reads return the live count again.
- R8: A read-back word (bits 7:6 = 11) acts on each channel whose select bit is set, with bits 1, 2 and 3 selecting channels 0, 1 and 2. Bit 5 low freezes the count and bit 4 low freezes the status. Unselected channels are left untouched.
- R9: The status byte is {out level, 0, access[1:0], mode[2:0], bcd}. It is not recaptured while a status byte is still pending.
- R10: A pending status byte is returned by the next data read, ahead of any frozen count, and is then dropped.
- R11: A read takes effect in the cycle after `rd_i`. A read of address 3 gives `rvalid_o` = 0 and `rdata_o` = 0. A read of a channel gives `rvalid_o` = 1.
- R12: Reset clears every freeze flag, both byte orders and the held byte. It sets access to 00 (data then behaves as low-only), mode to 0 and BCD to 0, with `load_o` and `rvalid_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Byte write strobe |
| rd_i | input | 1 | Byte read strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Read byte, valid the cycle after `rd_i` |
| rvalid_o | output | 1 | Read returned data |
| load_o | output | NCH | Per-channel initial value load strobe |
| load_val_o | output | NCH*16 | Per-channel initial value |
| mode_o | output | NCH*3 | Per-channel operating mode |
| bcd_o | output | NCH | Per-channel BCD flag |
| cnt_i | input | NCH*16 | Per-channel live count |
| out_i | input | NCH | Per-channel output level |

## Verification
The assertions assume that the host never raises `wr_i` and `rd_i` in the same cycle, so that a single bus operation decides each cycle's state change. The bench respects this by issuing every access through one task that raises a single strobe for exactly one cycle and lowers it before the next access begins. `cnt_i` and `out_i` change only between accesses, so that every freeze captures a value the bench knows.

// File: rtl/tmr_bus_pkg.sv
package tmr_bus_pkg;
  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_LOHI  = 2'b11
  } acc_e;

  localparam logic [1:0] CTL_ADDR = 2'd3;
  localparam logic [1:0] SEL_RDBK = 2'd3;
endpackage

// File: rtl/tmr_bus_decode.sv
module tmr_bus_decode
  import tmr_bus_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic           wr_i,
  input  logic           rd_i,
  input  logic [1:0]     addr_i,
  input  logic [7:0]     wdata_i,
  output logic [NCH-1:0] cfg_we_o,
  output logic [NCH-1:0] lat_cnt_o,
  output logic [NCH-1:0] lat_sts_o,
  output logic [NCH-1:0] dat_we_o,
  output logic [NCH-1:0] dat_re_o
);
  logic ctl_wr, rdbk;
  logic unused_bit0;

  assign ctl_wr      = wr_i && (addr_i == CTL_ADDR);
  assign rdbk        = ctl_wr && (wdata_i[7:6] == SEL_RDBK);
  assign unused_bit0 = wdata_i[0];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic plain, picked;
    assign plain  = ctl_wr && (wdata_i[7:6] == 2'(g));
    assign picked = rdbk && wdata_i[g+1];
    assign cfg_we_o[g]  = plain && (wdata_i[5:4] != 2'b00);
    assign lat_cnt_o[g] = (plain && (wdata_i[5:4] == 2'b00)) || (picked && !wdata_i[5]);
    assign lat_sts_o[g] = picked && !wdata_i[4];
    assign dat_we_o[g]  = wr_i && (addr_i == 2'(g));
    assign dat_re_o[g]  = rd_i && (addr_i == 2'(g));
  end
endmodule

// File: rtl/tmr_bus_chan.sv
module tmr_bus_chan
  import tmr_bus_pkg::*;
#(
  parameter int BW = 8,
  localparam int CW = 2 * BW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic          lat_cnt_i,
  input  logic          lat_sts_i,
  input  logic          dat_we_i,
  input  logic          dat_re_i,
  input  logic [BW-1:0] wdata_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          out_i,
  output logic          load_o,
  output logic [CW-1:0] load_val_o,
  output logic [2:0]    mode_o,
  output logic          bcd_o,
  output logic [BW-1:0] rbyte_o
);
  acc_e          acc_q, eff_acc, lat_st_q;
  logic [2:0]    mode_q;
  logic          bcd_q, wr_hi_q, rd_hi_q, sts_pend_q, load_q;
  logic [BW-1:0] hold_q, sts_q;
  logic [CW-1:0] lat_q, load_val_q;

  // access code 00 after reset behaves as low-only
  assign eff_acc = (acc_q == ACC_LATCH) ? ACC_LO : acc_q;

  always_comb begin
    if (sts_pend_q) begin
      rbyte_o = sts_q;
    end else if (lat_st_q != ACC_LATCH) begin
      rbyte_o = (lat_st_q == ACC_HI) ? lat_q[CW-1:BW] : lat_q[BW-1:0];
    end else begin
      unique case (eff_acc)
        ACC_HI:   rbyte_o = cnt_i[CW-1:BW];
        ACC_LOHI: rbyte_o = rd_hi_q ? cnt_i[CW-1:BW] : cnt_i[BW-1:0];
        default:  rbyte_o = cnt_i[BW-1:0];
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q      <= ACC_LATCH;
      mode_q     <= '0;
      bcd_q      <= 1'b0;
      wr_hi_q    <= 1'b0;
      rd_hi_q    <= 1'b0;
      hold_q     <= '0;
      lat_q      <= '0;
      lat_st_q   <= ACC_LATCH;
      sts_q      <= '0;
      sts_pend_q <= 1'b0;
      load_q     <= 1'b0;
      load_val_q <= '0;
    end else begin
      load_q <= 1'b0;
      if (cfg_we_i) begin
        acc_q   <= acc_e'(wdata_i[5:4]);
        mode_q  <= wdata_i[3:1];
        bcd_q   <= wdata_i[0];
        wr_hi_q <= 1'b0;
        rd_hi_q <= 1'b0;
      end
      if (lat_cnt_i && (lat_st_q == ACC_LATCH)) begin
        lat_q    <= cnt_i;
        lat_st_q <= eff_acc;
      end
      if (lat_sts_i && !sts_pend_q) begin
        sts_q      <= {out_i, 1'b0, acc_q, mode_q, bcd_q};
        sts_pend_q <= 1'b1;
      end
      if (dat_we_i) begin
        unique case (eff_acc)
          ACC_HI: begin
            load_q     <= 1'b1;
            load_val_q <= {wdata_i, {BW{1'b0}}};
          end
          ACC_LOHI: begin
            if (!wr_hi_q) begin
              hold_q  <= wdata_i;
              wr_hi_q <= 1'b1;
            end else begin
              load_q     <= 1'b1;
              load_val_q <= {wdata_i, hold_q};
              wr_hi_q    <= 1'b0;
            end
          end
          default: begin
            load_q     <= 1'b1;
            load_val_q <= {{BW{1'b0}}, wdata_i};
          end
        endcase
      end
      if (dat_re_i) begin
        if (sts_pend_q) begin
          sts_pend_q <= 1'b0;
        end else if (lat_st_q != ACC_LATCH) begin
          lat_st_q <= (lat_st_q == ACC_LOHI) ? ACC_HI : ACC_LATCH;
        end else if (eff_acc == ACC_LOHI) begin
          rd_hi_q <= !rd_hi_q;
        end
      end
    end
  end

  assign load_o     = load_q;
  assign load_val_o = load_val_q;
  assign mode_o     = mode_q;
  assign bcd_o      = bcd_q;
endmodule

// File: rtl/tmr_bus_regs.sv
module tmr_bus_regs
  import tmr_bus_pkg::*;
#(
  parameter int NCH = 3,
  parameter int BW  = 8,
  localparam int CW = 2 * BW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [1:0]       addr_i,
  input  logic [BW-1:0]    wdata_i,
  output logic [BW-1:0]    rdata_o,
  output logic             rvalid_o,
  output logic [NCH-1:0]   load_o,
  output logic [NCH*CW-1:0] load_val_o,
  output logic [NCH*3-1:0] mode_o,
  output logic [NCH-1:0]   bcd_o,
  input  logic [NCH*CW-1:0] cnt_i,
  input  logic [NCH-1:0]   out_i
);
  logic [NCH-1:0] cfg_we, lat_cnt, lat_sts, dat_we, dat_re;
  logic [BW-1:0]  rbyte [NCH];
  logic [BW-1:0]  rsel, rdata_q;
  logic           rvalid_q;

  tmr_bus_decode #(.NCH(NCH)) u_dec (
    .wr_i      (wr_i),
    .rd_i      (rd_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .cfg_we_o  (cfg_we),
    .lat_cnt_o (lat_cnt),
    .lat_sts_o (lat_sts),
    .dat_we_o  (dat_we),
    .dat_re_o  (dat_re)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    tmr_bus_chan #(.BW(BW)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_we_i   (cfg_we[g]),
      .lat_cnt_i  (lat_cnt[g]),
      .lat_sts_i  (lat_sts[g]),
      .dat_we_i   (dat_we[g]),
      .dat_re_i   (dat_re[g]),
      .wdata_i    (wdata_i),
      .cnt_i      (cnt_i[g*CW +: CW]),
      .out_i      (out_i[g]),
      .load_o     (load_o[g]),
      .load_val_o (load_val_o[g*CW +: CW]),
      .mode_o     (mode_o[g*3 +: 3]),
      .bcd_o      (bcd_o[g]),
      .rbyte_o    (rbyte[g])
    );
  end

  always_comb begin
    rsel = '0;
    for (int i = 0; i < NCH; i++) begin
      if (addr_i == 2'(i)) rsel = rbyte[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_i && (addr_i != CTL_ADDR);
      if (rd_i) rdata_q <= (addr_i != CTL_ADDR) ? rsel : '0;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/tmr_bus_chk.sv
module tmr_bus_chk #(
  parameter int NCH = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_i,
  input logic             rd_i,
  input logic [1:0]       addr_i,
  input logic             rvalid_o,
  input logic [NCH-1:0]   load_o,
  input logic [NCH*3-1:0] mode_o
);
  assert_single_op_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && rd_i));

  assert_ctl_read_silent_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 2'd3) |=> !rvalid_o);

  assert_data_read_valid_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i != 2'd3) |=> rvalid_o);

  assert_no_load_on_ctl_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 2'd3) |=> (load_o == '0));

  assert_mode_only_by_ctl_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == 2'd3) |=> $stable(mode_o));

  assert_load_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(load_o));

  for (genvar g = 0; g < NCH; g++) begin : g_ld
    assert_load_src_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_o[g] |-> $past(wr_i && addr_i == 2'(g)));
  end
endmodule

bind tmr_bus_regs tmr_bus_chk #(.NCH(NCH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_i     (wr_i),
  .rd_i     (rd_i),
  .addr_i   (addr_i),
  .rvalid_o (rvalid_o),
  .load_o   (load_o),
  .mode_o   (mode_o)
);

// File: tb/sim_tmr_bus_regs.sv
`timescale 1ns/1ps
module sim_tmr_bus_regs;
  localparam int NCH = 3;
  localparam int CW  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0, rd = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata_o;
  logic rvalid_o;
  logic [NCH-1:0] load_o;
  logic [NCH*CW-1:0] load_val_o;
  logic [NCH*3-1:0] mode_o;
  logic [NCH-1:0] bcd_o;
  logic [NCH*CW-1:0] cnt = '0;
  logic [NCH-1:0] outl = '0;

  int nchk = 0, nfail = 0;
  logic [NCH-1:0] ld_seen;
  logic [NCH*CW-1:0] ld_val;

  always #2.5 clk = ~clk;

  tmr_bus_regs #(.NCH(NCH), .BW(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata_o), .rvalid_o(rvalid_o), .load_o(load_o),
    .load_val_o(load_val_o), .mode_o(mode_o), .bcd_o(bcd_o),
    .cnt_i(cnt), .out_i(outl)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
    ld_seen = load_o; ld_val = load_val_o;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d, output logic v);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0;
    d = rdata_o; v = rvalid_o;
  endtask

  task automatic rd_exp(input int ch, input logic [7:0] e, input string req);
    logic [7:0] d; logic v;
    bus_rd(2'(ch), d, v);
    chk(v && d == e, req, {23'd0, v, d}, {24'd1, e});
  endtask

  initial begin
    logic [7:0] d; logic v;
    repeat (3) @(negedge clk);
    chk(mode_o == '0 && bcd_o == '0 && load_o == '0 && rvalid_o == 1'b0, "R12 reset outputs",
        {mode_o, bcd_o, load_o, rvalid_o}, 0);
    rst_n = 1'b1;
    // R12: access 00 acts as low-only
    bus_wr(2'd1, 8'hA7);
    chk(ld_seen == 3'b010 && ld_val[16 +: 16] == 16'h00A7, "R12 default low-only load", ld_val[16 +: 16], 16'h00A7);
    cnt[16 +: 16] = 16'hBEEF;
    rd_exp(1, 8'hEF, "R12 default low-only read");
    // R11
    bus_rd(2'd3, d, v);
    chk(!v && d == 8'h00, "R11 control read", {v, d}, 0);

    // R1..R4 sweep
    for (int ch = 0; ch < NCH; ch++)
      for (int acc = 1; acc < 4; acc++)
        for (int md = 0; md < 8; md++)
          for (int bc = 0; bc < 2; bc++) begin
            logic [7:0] b, b2; logic [15:0] c;
            bus_wr(2'd3, {2'(ch), 2'(acc), 3'(md), 1'(bc)});
            chk(mode_o[ch*3 +: 3] == 3'(md) && bcd_o[ch] == 1'(bc), "R1 mode/bcd",
                {mode_o[ch*3 +: 3], bcd_o[ch]}, {3'(md), 1'(bc)});
            chk(ld_seen == '0, "R1 no load on control", ld_seen, 0);
            b  = 8'(ch * 37 + acc * 11 + md * 5 + bc + 1);
            b2 = ~b;
            if (acc == 1) begin
              bus_wr(2'(ch), b);
              chk(ld_seen == 3'(1 << ch) && ld_val[ch*16 +: 16] == {8'h00, b}, "R2 low-only load",
                  ld_val[ch*16 +: 16], {8'h00, b});
            end else if (acc == 2) begin
              bus_wr(2'(ch), b);
              chk(ld_seen == 3'(1 << ch) && ld_val[ch*16 +: 16] == {b, 8'h00}, "R2 high-only load",
                  ld_val[ch*16 +: 16], {b, 8'h00});
            end else begin
              bus_wr(2'(ch), b);
              chk(ld_seen == '0, "R3 first byte held", ld_seen, 0);
              bus_wr(2'(ch), b2);
              chk(ld_seen == 3'(1 << ch) && ld_val[ch*16 +: 16] == {b2, b}, "R3 word load",
                  ld_val[ch*16 +: 16], {b2, b});
            end
            c = {b2, b} ^ 16'h5A3C;
            cnt[ch*16 +: 16] = c;
            if (acc == 1) rd_exp(ch, c[7:0], "R4 low-only read");
            else if (acc == 2) rd_exp(ch, c[15:8], "R4 high-only read");
            else begin
              rd_exp(ch, c[7:0], "R4 alt low");
              rd_exp(ch, c[15:8], "R4 alt high");
              rd_exp(ch, c[7:0], "R4 alt low again");
              rd_exp(ch, c[15:8], "R4 alt high again");
            end
          end

    // R5..R7 count freeze
    for (int ch = 0; ch < NCH; ch++)
      for (int acc = 1; acc < 4; acc++) begin
        logic [15:0] x, y;
        bus_wr(2'd3, {2'(ch), 2'(acc), 3'd2, 1'b0});
        x = 16'(16'h1234 + ch * 16'h1111 + acc);
        y = ~x;
        cnt[ch*16 +: 16] = x;
        bus_wr(2'd3, {2'(ch), 6'b000000});
        cnt[ch*16 +: 16] = y;
        bus_wr(2'd3, {2'(ch), 6'b000000}); // must be ignored (R6)
        if (acc == 1) rd_exp(ch, x[7:0], "R5 R6 frozen low");
        else if (acc == 2) rd_exp(ch, x[15:8], "R5 R6 frozen high");
        else begin
          rd_exp(ch, x[7:0], "R5 R6 frozen word low");
          rd_exp(ch, x[15:8], "R5 R6 frozen word high");
        end
        if (acc == 2) rd_exp(ch, y[15:8], "R7 live after freeze");
        else rd_exp(ch, y[7:0], "R7 live after freeze");
      end

    // R8..R10 read-back sweep over channel masks
    for (int ch = 0; ch < NCH; ch++)
      bus_wr(2'd3, {2'(ch), 2'b11, 3'(ch + 1), 1'(ch & 1)});
    for (int m = 1; m < 8; m++) begin
      logic [15:0] z [NCH];
      logic [NCH-1:0] o;
      for (int ch = 0; ch < NCH; ch++) begin
        z[ch] = 16'(m * 16'h0101 + ch * 16'h0010 + 16'h2000);
        cnt[ch*16 +: 16] = z[ch];
        o[ch] = 1'((m ^ ch) & 1);
      end
      outl = o;
      bus_wr(2'd3, {2'b11, 2'b00, 3'(m), 1'b0});
      for (int ch = 0; ch < NCH; ch++) cnt[ch*16 +: 16] = ~z[ch];
      outl = ~o;
      for (int ch = 0; ch < NCH; ch++) begin
        logic [15:0] nz;
        nz = ~z[ch];
        if (m[ch]) begin
          rd_exp(ch, {o[ch], 1'b0, 2'b11, 3'(ch + 1), 1'(ch & 1)}, "R8 R9 R10 status first");
          rd_exp(ch, z[ch][7:0], "R8 frozen low");
          rd_exp(ch, z[ch][15:8], "R8 frozen high");
        end
        rd_exp(ch, nz[7:0], "R8 R7 live low");
        rd_exp(ch, nz[15:8], "R8 R7 live high");
      end
    end

    // R9 status not recaptured while pending; R10 cleared after read
    bus_wr(2'd3, 8'b00_11_010_0);
    cnt[15:0] = 16'h4321;
    outl[0] = 1'b1;
    bus_wr(2'd3, 8'b11_1_0_001_0);
    outl[0] = 1'b0;
    bus_wr(2'd3, 8'b11_1_0_001_0);
    rd_exp(0, 8'b1_0_11_010_0, "R9 status kept");
    rd_exp(0, 8'h21, "R10 status dropped");
    rd_exp(0, 8'h43, "R10 live high");
    // R10 status ahead of earlier frozen count
    bus_wr(2'd3, 8'b00_00_0000);
    cnt[15:0] = 16'h9999;
    bus_wr(2'd3, 8'b11_1_0_001_0);
    rd_exp(0, 8'b0_0_11_010_0, "R10 status before count");
    rd_exp(0, 8'h21, "R10 count low");
    rd_exp(0, 8'h43, "R10 count high");
    // R8 count-only read-back
    bus_wr(2'd3, 8'b11_0_1_001_0);
    cnt[15:0] = 16'h0000;
    rd_exp(0, 8'h99, "R8 count-only low");
    rd_exp(0, 8'h99, "R8 count-only high");
    bus_rd(2'd3, d, v);
    chk(!v && d == 8'h00, "R11 control read late", {v, d}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(5 * 150000);
    nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule